// File: doc/BRIEF.md
# Non-Preemptive Thread Context Arbiter

This block chooses which hardware thread of a multithreaded packet engine owns the engine's single pipeline. Every thread is in one of two states. It is either ready, meaning it can run, or parked, meaning it is waiting for an outstanding memory reference to complete. Exactly one ready thread holds the pipeline at a time. It keeps the pipeline until it gives control back with a one-cycle yield pulse, which it typically raises when it issues a memory reference. The yielding thread is parked. The grant then moves to the next ready thread in circular order, and the search starts just after the yielder. When the memory system completes that reference, it pulses the thread's wake input and the thread becomes ready again.

While a thread holds the pipeline, wake-ups never take the grant away from it. When every thread is parked, the grant is empty and the idle output is high for every such cycle. Power management can count these cycles. While idle, the first thread that wakes gets the grant on the next cycle. A wake pulse aimed at a thread that is not parked is dropped, and an error pulse is raised. This includes a wake that arrives in the same cycle as that thread's own yield.

Top module: `ctx_arbiter`

## Requirements
- R1: After reset all threads are ready, the grant is 4'b0001 (thread 0, bit i = thread i), idle is 0 and the error output is 0.
- R2: The grant is one-hot or all zero. Idle is 1 exactly when the grant is all zero, which is exactly when no thread is ready.
- R3: While a thread holds the grant and yield is 0, the grant does not change in the next cycle, even if parked threads wake.
- R4: A yield while a thread holds the grant parks that thread. In the next cycle the grant goes to the first ready thread found by scanning upward from the yielder's index plus one, wrapping to thread 0.
- R5: A parked thread is never granted until its wake bit is pulsed. The pulse makes it ready from the next cycle.
- R6: When the last ready thread yields, the next cycle shows idle 1 and a zero grant, and this holds every cycle until a wake arrives.
- R7: While idle, a wake gives the grant in the next cycle. If several threads wake together, the scan starts at the last yielder's index plus one.
- R8: A wake for a thread that is not parked is dropped, including a wake in the same cycle as that thread's yield. The error output is 1 in the following cycle only.
- R9: A yield while idle has no effect: idle stays 1 and the error output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| yield_i | input | 1 | One-cycle pulse from the thread that holds the grant, giving up the pipeline |
| wake_i | input | NUM_THREADS | One-cycle pulse per thread when its memory reference completes |
| grant_o | output | NUM_THREADS | One-hot pipeline owner, all zero when idle |
| idle_o | output | 1 | High in every cycle in which no thread is ready |
| wake_err_o | output | 1 | One-cycle pulse after a wake aimed at a thread that was not parked |

## Verification
The assertions assume that yield is raised only by the thread that holds the grant, so a yield while idle is treated as noise. They also assume that each wake pulse answers one earlier yield of the same thread. The directed stimulus follows these rules in every scenario except two deliberate ones. In one, a yield is driven while idle. In the other, wakes are aimed at threads that are running or yielding in the same cycle. Those two cases are checked at the ports through the grant, idle and error outputs. Wake-ups are spaced by the 12, 16 and 33 cycle unloaded memory latencies, so idle has to hold through long stretches.

// File: rtl/ctx_arb_pkg.sv
package ctx_arb_pkg;

   // Circular successor of a thread index within a pool of n threads.
   function automatic int unsigned ring_succ(input int unsigned idx, input int unsigned n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/ctx_thread_slot.sv
module ctx_thread_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic park_i,
   input  logic wake_i,
   output logic ready_o,
   output logic spurious_o
);
   logic ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                  ready_q <= 1'b1;
      else if (park_i)             ready_q <= 1'b0;
      else if (wake_i && !ready_q) ready_q <= 1'b1;
   end

   assign ready_o    = ready_q;
   assign spurious_o = wake_i & ready_q;

   AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_i && !ready_q) |=> ready_q);                        // R5
   AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_q && !wake_i) |=> !ready_q);                      // R5
   AST_PARK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      park_i |=> !ready_q);                                     // R8
endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
   parameter int unsigned NUM_THREADS = 4,
   localparam int unsigned IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic [NUM_THREADS-1:0] ready_i,
   input  logic [IDX_W-1:0]       start_i,
   output logic                   found_o,
   output logic [IDX_W-1:0]       idx_o,
   output logic [NUM_THREADS-1:0] onehot_o
);
   always_comb begin
      found_o  = 1'b0;
      idx_o    = '0;
      onehot_o = '0;
      for (int i = 0; i < int'(NUM_THREADS); i++) begin
         int cand;
         cand = int'(start_i) + i;
         if (cand >= int'(NUM_THREADS)) cand = cand - int'(NUM_THREADS);
         if (!found_o && ready_i[cand]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(cand);
         end
      end
      if (found_o) onehot_o[idx_o] = 1'b1;
   end

   always_comb begin
      AST_PICK_READY: assert ((onehot_o & ~ready_i) == '0);      // R5
      AST_PICK_FOUND: assert (found_o == (ready_i != '0));       // R2
   end
endmodule

// File: rtl/ctx_arbiter.sv
module ctx_arbiter #(
   parameter int unsigned NUM_THREADS = 4,
   localparam int unsigned IDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   yield_i,
   input  logic [NUM_THREADS-1:0] wake_i,
   output logic [NUM_THREADS-1:0] grant_o,
   output logic                   idle_o,
   output logic                   wake_err_o
);
   import ctx_arb_pkg::*;

   initial begin : param_check
      assert (NUM_THREADS >= 2 && NUM_THREADS <= 64)
         else $error("ctx_arbiter: NUM_THREADS out of range");
   end

   logic [NUM_THREADS-1:0] grant_q, ready_vec, spurious_vec, park_vec, ready_next;
   logic [IDX_W-1:0]       owner_q, ptr_q, owner_succ, scan_start, pick_idx;
   logic                   err_q, running, yield_eff, need_pick, pick_found;
   logic [NUM_THREADS-1:0] pick_onehot;

   assign running    = (grant_q != '0);
   assign yield_eff  = yield_i & running;
   assign owner_succ = IDX_W'(ring_succ(int'(owner_q), NUM_THREADS));

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
      assign park_vec[t]   = yield_eff && (owner_q == IDX_W'(t));
      assign ready_next[t] = (ready_vec[t] & ~park_vec[t]) | (wake_i[t] & ~ready_vec[t]);
      ctx_thread_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .park_i    (park_vec[t]),
         .wake_i    (wake_i[t]),
         .ready_o   (ready_vec[t]),
         .spurious_o(spurious_vec[t])
      );
   end

   assign need_pick  = yield_eff | ~running;
   assign scan_start = yield_eff ? owner_succ : ptr_q;

   ctx_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
      .ready_i (ready_next),
      .start_i (scan_start),
      .found_o (pick_found),
      .idx_o   (pick_idx),
      .onehot_o(pick_onehot)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q <= NUM_THREADS'(1);
         owner_q <= '0;
         ptr_q   <= IDX_W'(1);
         err_q   <= 1'b0;
      end else begin
         err_q <= |spurious_vec;
         if (yield_eff) ptr_q <= owner_succ;
         if (need_pick) begin
            grant_q <= pick_onehot;
            if (pick_found) owner_q <= pick_idx;
         end
      end
   end

   assign grant_o    = grant_q;
   assign idle_o     = ~running;
   assign wake_err_o = err_q;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));                                          // R2
   AST_IDLE_NONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      idle_o == (ready_vec == '0));                                // R2
   AST_GRANT_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~ready_vec) == '0);                               // R5
   AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!yield_i && !idle_o) |=> $stable(grant_o));                  // R3
   AST_YIELD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (yield_i && !idle_o) |=> (grant_o != $past(grant_o)));        // R4
   AST_IDLE_YIELD_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (yield_i && idle_o && wake_i == '0) |=> idle_o);             // R9
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((wake_i & ready_vec) != '0) |=> wake_err_o);                // R8
endmodule

// File: tb/tb_ctx_arbiter.sv
module tb_ctx_arbiter;
   localparam int NT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          yield_i = 1'b0;
   logic [NT-1:0] wake_i = '0;
   logic [NT-1:0] grant_o;
   logic          idle_o;
   logic          wake_err_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #4 clk = ~clk;

   ctx_arbiter #(.NUM_THREADS(NT)) dut (
      .clk(clk), .rst_n(rst_n), .yield_i(yield_i), .wake_i(wake_i),
      .grant_o(grant_o), .idle_o(idle_o), .wake_err_o(wake_err_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic y, input logic [NT-1:0] w);
      @(negedge clk);
      yield_i = y;
      wake_i  = w;
      @(posedge clk);
      #2;
      yield_i = 1'b0;
      wake_i  = '0;
   endtask

   task automatic expect_out(input string req, input int g, input int idl, input int err);
      chk(req, "grant", int'(grant_o), g);
      chk(req, "idle", int'(idle_o), idl);
      chk(req, "wake_err", int'(wake_err_o), err);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      expect_out("R1", 'b0001, 0, 0);
   endtask

   task automatic t_hold_grant;
      step(1'b1, 4'b0000); expect_out("R4", 'b0010, 0, 0);
      step(1'b0, 4'b0001); expect_out("R3", 'b0010, 0, 0);
   endtask

   task automatic t_rotation;
      step(1'b1, 4'b0000); expect_out("R4", 'b0100, 0, 0);
      step(1'b1, 4'b0000); expect_out("R4", 'b1000, 0, 0);
      step(1'b1, 4'b0000); expect_out("R4", 'b0001, 0, 0);
      step(1'b1, 4'b0000); expect_out("R6", 'b0000, 1, 0);
   endtask

   task automatic t_idle_yield;
      step(1'b1, 4'b0000); expect_out("R9", 'b0000, 1, 0);
   endtask

   task automatic t_idle_multi_wake;
      step(1'b0, 4'b1100); expect_out("R7", 'b0100, 0, 0);
   endtask

   task automatic t_latency(input int lat, input logic [NT-1:0] who);
      step(1'b1, 4'b0000); expect_out("R6", 'b0000, 1, 0);
      for (int i = 0; i < lat - 1; i++) begin
         step(1'b0, 4'b0000);
         chk("R6", "idle hold", int'(idle_o), 1);
      end
      step(1'b0, who); expect_out("R5", int'(who), 0, 0);
   endtask

   task automatic t_wake_errors;
      step(1'b1, 4'b0010); expect_out("R8", 'b0000, 1, 1);
      step(1'b0, 4'b0000); expect_out("R8", 'b0000, 1, 0);
      step(1'b0, 4'b0010); expect_out("R7", 'b0010, 0, 0);
      step(1'b0, 4'b0010); expect_out("R8", 'b0010, 0, 1);
   endtask

   task automatic t_wake_no_preempt;
      step(1'b0, 4'b1101); expect_out("R3", 'b0010, 0, 0);
      step(1'b1, 4'b0000); expect_out("R4", 'b0100, 0, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      t_reset();
      t_hold_grant();
      t_rotation();
      t_idle_yield();
      t_idle_multi_wake();
      step(1'b1, 4'b0000); expect_out("R4", 'b1000, 0, 0);
      t_latency(12, 4'b0001);
      t_latency(16, 4'b0010);
      t_latency(33, 4'b0010);
      t_wake_errors();
      t_wake_no_preempt();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule